// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port that moves eight bits per transfer alongside a shared transfer clock. The host writes a byte into a transmit holding register. That byte moves into a transmit shift register when a transfer starts. In the same transfer, a receive shift register collects eight bits from the data input and then hands the byte to a receive holding register. The transfer clock comes from one of two places. In internal mode the block divides one of several prescaled tick inputs by a programmable divisor and drives the clock pin. In external mode it follows a clock pin that it synchronises into the system clock domain.

Reception never runs by itself. The receive clock exists only while a transmit transfer is in progress. The host chooses the clock polarity, the bit order and when the transmit interrupt fires. It can also turn on a continuous-receive mode, in which reading the receive holding register starts the next transfer. An overrun flag catches a byte that arrives before the previous one was read.

Top module: `syncSerialPort`

## Requirements
- R1: After reset, txEmpty is 1, overrun, txIrq and rxIrq are 0, and sckOut rests at its idle level, which is high when clkPol is 0.
- R2: In internal mode, one transfer-clock period lasts 2*(divisor+1) pulses of srcTick[clkSel].
- R3: With clkPol=0 the clock idles high, transmit data changes on falling edges and receive data is sampled on rising edges. With clkPol=1 the clock idles low and both edges swap roles.
- R4: A transfer starts only when txEn is 1 and the transmit holding register is full. Until then sckOut stays idle and txEmpty stays 0.
- R5: txEmpty goes to 1 when the held byte moves into the shift register. A write clears it, and a write in that same cycle takes priority.
- R6: With txIrqOnDone=0, txIrq pulses in the cycle txEmpty rises. With txIrqOnDone=1, it pulses when the eighth bit completes, in the same cycle as rxIrq.
- R7: If rxEn is 1 when a transfer starts, then once the eighth bit is sampled rdData holds the received byte and rxIrq pulses for one cycle. If rxEn is 0 at the start, rxIrq stays low and rdData is unchanged.
- R8: msbFirst=1 sends and receives bit 7 first. msbFirst=0 sends and receives bit 0 first.
- R9: overrun is set when the seventh bit of a byte is sampled while the previously received byte is still unread. That byte is then discarded, rdData keeps the old value and rxIrq does not pulse. overrun stays clear whenever rxEn is 0.
- R10: With contRx=1, a read pulse on rdStrobe starts a new transfer with no new write. The transfer re-sends the byte in the transmit holding register and receives a new byte.
- R11: In external mode, sckIn is synchronised and then used with the edge roles of R3, and sckOut is held at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| txEn | input | 1 | Transmit enable |
| rxEn | input | 1 | Receive enable |
| extMode | input | 1 | 1 selects the external transfer clock on sckIn |
| clkPol | input | 1 | Clock polarity select |
| msbFirst | input | 1 | Bit order select |
| txIrqOnDone | input | 1 | 0: transmit interrupt at start, 1: at completion |
| contRx | input | 1 | Continuous-receive mode |
| clkSel | input | 2 | Selects the prescaled tick source |
| divisor | input | 8 | Internal clock divisor n |
| srcTick | input | 4 | Prescaled tick enables, one per source |
| wrValid | input | 1 | Write strobe for the transmit holding register |
| wrData | input | 8 | Byte to transmit |
| rdStrobe | input | 1 | Read strobe for the receive holding register |
| rdData | output | 8 | Receive holding register |
| txEmpty | output | 1 | Transmit holding register empty |
| overrun | output | 1 | Overrun flag |
| txIrq | output | 1 | Transmit interrupt pulse |
| rxIrq | output | 1 | Receive interrupt pulse |
| sckIn | input | 1 | External transfer clock |
| sckOut | output | 1 | Generated transfer clock |
| rxdIn | input | 1 | Serial data in |
| txdOut | output | 1 | Serial data out |

## Verification
The bench builds the block with its default parameters: eight data bits, an 8-bit divisor, four tick sources and a two-stage synchroniser. Because the divisor is an input, small values keep each frame to a few dozen cycles. Tick sources that pulse every cycle, every second cycle and every fourth cycle let the clock period be measured against the 2*(n+1) rule for more than one source. The serial output is looped back to the input, and a monitor decodes every frame from the line clock on its own. Both bit orders, both polarities, the external clock path, overrun and continuous receive can therefore all be reached in a short run.

// File: rtl/sspPkg.sv
package sspPkg;
  typedef struct packed {
    logic load;      // move holding byte into tx shifter
    logic shiftTx;   // advance tx shifter
    logic sampleRx;  // capture one rx bit
    logic commitRx;  // move assembled byte into rx holding register
  } sspStrobe_t;
endpackage

// File: rtl/sspClkGen.sv
module sspClkGen #(
  parameter int DIV_W       = 8,
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               active,
  input  logic               extMode,
  input  logic               clkPol,
  input  logic [SEL_W-1:0]   clkSel,
  input  logic [DIV_W-1:0]   divisor,
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic               sckIn,
  output logic               driveEdge,
  output logic               sampleEdge,
  output logic               sckOut
);
  logic [DIV_W-1:0]     divCnt;
  logic                 phase;
  logic [SYNC_STAGES:0] syncQ;
  logic                 tick, intEdge, extRise, extFall, extOn;

  assign tick    = srcTick[clkSel];
  assign intEdge = active && !extMode && tick && (divCnt == divisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      phase  <= 1'b0;
    end else if (!active || extMode) begin
      divCnt <= '0;
      phase  <= 1'b0;
    end else if (tick) begin
      if (divCnt == divisor) begin
        divCnt <= '0;
        phase  <= ~phase;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // synchroniser plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], sckIn};
  end

  assign extRise = syncQ[SYNC_STAGES-1] && !syncQ[SYNC_STAGES];
  assign extFall = !syncQ[SYNC_STAGES-1] && syncQ[SYNC_STAGES];
  assign extOn   = active && extMode;

  // leaving the idle level is the drive edge, returning is the sample edge
  assign driveEdge  = (intEdge && !phase) || (extOn && (clkPol ? extRise : extFall));
  assign sampleEdge = (intEdge &&  phase) || (extOn && (clkPol ? extFall : extRise));
  assign sckOut     = phase ^ ~clkPol;
endmodule

// File: rtl/sspCtrl.sv
module sspCtrl
  import sspPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OVR_BIT = 7,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  input  logic       rxEn,
  input  logic       contRx,
  input  logic       txIrqOnDone,
  input  logic       wrValid,
  input  logic       rdStrobe,
  input  logic       driveEdge,
  input  logic       sampleEdge,
  output logic       active,
  output sspStrobe_t strobe,
  output logic       txEmpty,
  output logic       overrun,
  output logic       txIrq,
  output logic       rxIrq
);
  logic             bufFull, rxOn, rxFull, rearm, frameOvr;
  logic [CNT_W-1:0] bitCnt;
  logic             startOk, lastBit, ovrNow;

  assign startOk = !active && txEn && (bufFull || rearm);
  assign lastBit = active && sampleEdge && (bitCnt == CNT_W'(DATA_W - 1));
  assign ovrNow  = active && sampleEdge && rxOn && rxFull && (bitCnt == CNT_W'(OVR_BIT - 1));

  assign strobe.load     = startOk;
  assign strobe.shiftTx  = active && driveEdge && (bitCnt != '0);
  assign strobe.sampleRx = active && sampleEdge && rxOn;
  assign strobe.commitRx = lastBit && rxOn && !frameOvr && !ovrNow;
  assign txEmpty         = !bufFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      bufFull  <= 1'b0;
      rxOn     <= 1'b0;
      rxFull   <= 1'b0;
      rearm    <= 1'b0;
      frameOvr <= 1'b0;
      bitCnt   <= '0;
      overrun  <= 1'b0;
      txIrq    <= 1'b0;
      rxIrq    <= 1'b0;
    end else begin
      txIrq <= (startOk && bufFull && !txIrqOnDone) || (lastBit && txIrqOnDone);
      rxIrq <= strobe.commitRx;

      if (wrValid)      bufFull <= 1'b1;
      else if (startOk) bufFull <= 1'b0;

      if (startOk)      active <= 1'b1;
      else if (lastBit) active <= 1'b0;

      if (startOk) begin
        bitCnt   <= '0;
        rxOn     <= rxEn;
        frameOvr <= 1'b0;
      end else begin
        if (active && sampleEdge) bitCnt <= bitCnt + 1'b1;
        if (ovrNow)               frameOvr <= 1'b1;
      end

      if (!rxEn)       overrun <= 1'b0;
      else if (ovrNow) overrun <= 1'b1;

      if (strobe.commitRx) rxFull <= 1'b1;
      else if (rdStrobe)   rxFull <= 1'b0;

      if (startOk)                 rearm <= 1'b0;
      else if (!contRx)            rearm <= 1'b0;
      else if (rdStrobe)           rearm <= 1'b1;
    end
  end
endmodule

// File: rtl/sspData.sv
module sspData
  import sspPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msbFirst,
  input  logic              rxdIn,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  sspStrobe_t        strobe,
  output logic              txdOut,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] txBuf, txShift, rxShift, rxNext;

  assign rxNext = msbFirst ? {rxShift[DATA_W-2:0], rxdIn}
                           : {rxdIn, rxShift[DATA_W-1:1]};
  assign txdOut = msbFirst ? txShift[DATA_W-1] : txShift[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      txShift <= '1;
      rxShift <= '0;
      rdData  <= '0;
    end else begin
      if (wrValid) txBuf <= wrData;
      if (strobe.load)
        txShift <= txBuf;
      else if (strobe.shiftTx)
        txShift <= msbFirst ? {txShift[DATA_W-2:0], 1'b1} : {1'b1, txShift[DATA_W-1:1]};
      if (strobe.sampleRx) rxShift <= rxNext;
      if (strobe.commitRx) rdData  <= rxNext;
    end
  end
endmodule

// File: rtl/syncSerialPort.sv
module syncSerialPort
  import sspPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int OVR_BIT     = 7,
  localparam int SEL_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txEn,
  input  logic               rxEn,
  input  logic               extMode,
  input  logic               clkPol,
  input  logic               msbFirst,
  input  logic               txIrqOnDone,
  input  logic               contRx,
  input  logic [SEL_W-1:0]   clkSel,
  input  logic [DIV_W-1:0]   divisor,
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic               wrValid,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               rdStrobe,
  output logic [DATA_W-1:0]  rdData,
  output logic               txEmpty,
  output logic               overrun,
  output logic               txIrq,
  output logic               rxIrq,
  input  logic               sckIn,
  output logic               sckOut,
  input  logic               rxdIn,
  output logic               txdOut
);
  sspStrobe_t strobe;
  logic       active, driveEdge, sampleEdge;

  sspClkGen #(.DIV_W(DIV_W), .NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rstN(rstN), .active(active), .extMode(extMode), .clkPol(clkPol),
    .clkSel(clkSel), .divisor(divisor), .srcTick(srcTick), .sckIn(sckIn),
    .driveEdge(driveEdge), .sampleEdge(sampleEdge), .sckOut(sckOut)
  );

  sspCtrl #(.DATA_W(DATA_W), .OVR_BIT(OVR_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEn(txEn), .rxEn(rxEn), .contRx(contRx),
    .txIrqOnDone(txIrqOnDone), .wrValid(wrValid), .rdStrobe(rdStrobe),
    .driveEdge(driveEdge), .sampleEdge(sampleEdge), .active(active), .strobe(strobe),
    .txEmpty(txEmpty), .overrun(overrun), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  sspData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .msbFirst(msbFirst), .rxdIn(rxdIn), .wrValid(wrValid),
    .wrData(wrData), .strobe(strobe), .txdOut(txdOut), .rdData(rdData)
  );
endmodule

// File: rtl/sspChecker.sv
module sspChecker (
  input logic clk,
  input logic rstN,
  input logic rxEn,
  input logic extMode,
  input logic clkPol,
  input logic txIrqOnDone,
  input logic wrValid,
  input logic txEmpty,
  input logic overrun,
  input logic txIrq,
  input logic rxIrq,
  input logic sckOut
);
  assert_wr_clears_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !txEmpty);

  assert_ovr_needs_rxen_R9: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(rxEn));

  assert_rxirq_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

  assert_txirq_at_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txIrq && !$past(txIrqOnDone) && !$past(wrValid)) |-> txEmpty);

  assert_ext_clk_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && $past(extMode)) |-> (sckOut == !clkPol));
endmodule

bind syncSerialPort sspChecker u_chk (
  .clk(clk), .rstN(rstN), .rxEn(rxEn), .extMode(extMode), .clkPol(clkPol),
  .txIrqOnDone(txIrqOnDone), .wrValid(wrValid), .txEmpty(txEmpty), .overrun(overrun),
  .txIrq(txIrq), .rxIrq(rxIrq), .sckOut(sckOut)
);

// File: tb/syncSerialPort_tb.sv
`timescale 1ns/1ps
module syncSerialPort_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, txEn, rxEn, extMode, clkPol, msbFirst, txIrqOnDone, contRx;
  logic [1:0] clkSel;
  logic [7:0] divisor, wrData, rdData;
  logic [3:0] srcTick;
  logic wrValid, rdStrobe, txEmpty, overrun, txIrq, rxIrq, sckIn, sckOut, txdOut;
  logic [7:0] tc;

  syncSerialPort u_dut (
    .clk(clk), .rstN(rstN), .txEn(txEn), .rxEn(rxEn), .extMode(extMode), .clkPol(clkPol),
    .msbFirst(msbFirst), .txIrqOnDone(txIrqOnDone), .contRx(contRx), .clkSel(clkSel),
    .divisor(divisor), .srcTick(srcTick), .wrValid(wrValid), .wrData(wrData),
    .rdStrobe(rdStrobe), .rdData(rdData), .txEmpty(txEmpty), .overrun(overrun),
    .txIrq(txIrq), .rxIrq(rxIrq), .sckIn(sckIn), .sckOut(sckOut), .rxdIn(txdOut),
    .txdOut(txdOut)
  );

  always @(posedge clk) tc <= tc + 8'd1;
  assign srcTick = {tc[2:0] == 3'd0, tc[1:0] == 2'd0, tc[0] == 1'b0, 1'b1};

  int nChecks = 0, nFails = 0, cyc = 0;
  int txIrqCyc = -1, rxIrqCyc = -1, emptyRiseCyc = -1, rxIrqCnt = 0;
  logic [7:0] expQ[$];
  logic monEn = 1'b0, prevLine = 1'b1, prevEmpty = 1'b1;
  logic [7:0] shiftCur = '0;
  int bitsSeen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    logic line;
    logic sEdge;
    cyc++;
    #1;
    if (txIrq) txIrqCyc = cyc;
    if (rxIrq) begin rxIrqCyc = cyc; rxIrqCnt++; end
    if (txEmpty && !prevEmpty) emptyRiseCyc = cyc;
    prevEmpty = txEmpty;
    line  = extMode ? sckIn : sckOut;
    sEdge = clkPol ? (prevLine && !line) : (!prevLine && line);
    prevLine = line;
    if (!monEn) bitsSeen = 0;
    else if (sEdge) begin
      shiftCur = msbFirst ? {shiftCur[6:0], txdOut} : {txdOut, shiftCur[7:1]};
      bitsSeen++;
      if (bitsSeen == 8) begin
        bitsSeen = 0;
        if (expQ.size() == 0) check(0, "R3", "unexpected serial frame", shiftCur, 0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(shiftCur == e, "R8", "serial frame on line (R3 edges)", shiftCur, e);
        end
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    wrValid = 1'b1; wrData = b;
    expQ.push_back(b);
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic readRx;
    @(negedge clk) rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finishRun();
  end

  initial begin
    int t0, t1, cnt0;
    tc = '0;
    rstN = 0; txEn = 0; rxEn = 0; extMode = 0; clkPol = 0; msbFirst = 0;
    txIrqOnDone = 0; contRx = 0; clkSel = 0; divisor = 8'd2;
    wrValid = 0; wrData = '0; rdStrobe = 0; sckIn = 1;
    waitCyc(4);
    check(txEmpty == 1, "R1", "txEmpty after reset", txEmpty, 1);
    check(overrun == 0, "R1", "overrun after reset", overrun, 0);
    check(txIrq == 0,   "R1", "txIrq after reset", txIrq, 0);
    check(rxIrq == 0,   "R1", "rxIrq after reset", rxIrq, 0);
    check(sckOut == 1,  "R1", "sckOut idle after reset", sckOut, 1);
    rstN = 1;
    waitCyc(3);
    monEn = 1;

    // R4/R5: no transfer without txEn
    rxEn = 1;
    send(8'hA5);
    waitCyc(40);
    check(txEmpty == 0, "R5", "txEmpty after write", txEmpty, 0);
    check(sckOut == 1,  "R4", "clock idle while txEn=0", sckOut, 1);
    check(rxIrqCnt == 0, "R4", "no reception while txEn=0", rxIrqCnt, 0);

    // R6 start-mode interrupt, R7 reception
    txEn = 1;
    waitCyc(80);
    check(rxIrqCnt == 1, "R7", "rxIrq count", rxIrqCnt, 1);
    check(rdData == 8'hA5, "R7", "received byte", rdData, 8'hA5);
    check(txIrqCyc == emptyRiseCyc, "R6", "txIrq cycle vs txEmpty rise", txIrqCyc, emptyRiseCyc);
    readRx();

    // R6 done-mode interrupt
    txIrqOnDone = 1;
    send(8'h3C);
    waitCyc(80);
    check(txIrqCyc == rxIrqCyc, "R6", "txIrq cycle vs rxIrq in done mode", txIrqCyc, rxIrqCyc);
    check(rdData == 8'h3C, "R7", "received byte", rdData, 8'h3C);
    readRx();
    txIrqOnDone = 0;

    // R2: period with tick every 2 cycles, n=2 -> 12 cycles
    clkSel = 2'd1;
    send(8'h0F);
    while (sckOut != 0) @(negedge clk);
    t0 = cyc;
    while (sckOut != 1) @(negedge clk);
    while (sckOut != 0) @(negedge clk);
    t1 = cyc;
    check(t1 - t0 == 12, "R2", "clock period src1 n=2", t1 - t0, 12);
    waitCyc(150);
    check(rdData == 8'h0F, "R2", "byte at slower clock", rdData, 8'h0F);
    readRx();
    // tick every 4 cycles, n=0 -> 8 cycles
    clkSel = 2'd2; divisor = 8'd0;
    send(8'hE7);
    while (sckOut != 0) @(negedge clk);
    t0 = cyc;
    while (sckOut != 1) @(negedge clk);
    while (sckOut != 0) @(negedge clk);
    t1 = cyc;
    check(t1 - t0 == 8, "R2", "clock period src2 n=0", t1 - t0, 8);
    waitCyc(100);
    readRx();
    clkSel = 2'd0; divisor = 8'd2;

    // R3/R8: inverted polarity, MSB first
    monEn = 0; clkPol = 1; msbFirst = 1;
    waitCyc(3);
    monEn = 1;
    check(sckOut == 0, "R3", "idle level with clkPol=1", sckOut, 0);
    send(8'hC1);
    waitCyc(80);
    check(rdData == 8'hC1, "R8", "MSB-first received byte", rdData, 8'hC1);
    readRx();

    // R7: reception disabled
    rxEn = 0;
    cnt0 = rxIrqCnt;
    send(8'h77);
    waitCyc(80);
    check(rxIrqCnt == cnt0, "R7", "no rxIrq with rxEn=0", rxIrqCnt, cnt0);
    check(rdData == 8'hC1, "R7", "rdData kept with rxEn=0", rdData, 8'hC1);

    // R9: overrun on back-to-back unread bytes
    rxEn = 1;
    cnt0 = rxIrqCnt;
    send(8'h11);
    send(8'h22);
    waitCyc(160);
    check(rxIrqCnt == cnt0 + 1, "R9", "rxIrq count over overrun", rxIrqCnt, cnt0 + 1);
    check(rdData == 8'h11, "R9", "rdData keeps first byte", rdData, 8'h11);
    check(overrun == 1, "R9", "overrun set", overrun, 1);
    rxEn = 0;
    waitCyc(2);
    check(overrun == 0, "R9", "overrun cleared by rxEn=0", overrun, 0);
    rxEn = 1;
    readRx();

    // R10: continuous receive
    contRx = 1;
    cnt0 = rxIrqCnt;
    send(8'h5A);
    waitCyc(80);
    check(rdData == 8'h5A, "R10", "first byte in continuous mode", rdData, 8'h5A);
    expQ.push_back(8'h5A);
    readRx();
    waitCyc(80);
    check(rxIrqCnt == cnt0 + 2, "R10", "read re-armed reception", rxIrqCnt, cnt0 + 2);
    contRx = 0;
    readRx();

    // R11: external clock, clkPol=0, LSB first
    monEn = 0; extMode = 1; clkPol = 0; msbFirst = 0; sckIn = 1;
    waitCyc(4);
    monEn = 1;
    cnt0 = rxIrqCnt;
    send(8'h96);
    waitCyc(4);
    check(sckOut == 1, "R11", "sckOut held idle in external mode", sckOut, 1);
    for (int i = 0; i < 8; i++) begin
      sckIn = 0; waitCyc(8);
      sckIn = 1; waitCyc(8);
    end
    waitCyc(10);
    check(rdData == 8'h96, "R11", "byte on external clock", rdData, 8'h96);
    check(rxIrqCnt == cnt0 + 1, "R11", "rxIrq on external clock", rxIrqCnt, cnt0 + 1);
    check(expQ.size() == 0, "R8", "all frames seen on line", expQ.size(), 0);

    finishRun();
  end
endmodule